// File: doc/BRIEF.md
# Branch Folding Unit with Static Direction Hint

This unit takes branch instructions out of the instruction stream, one at a time. An unconditional branch is accepted and the unit asks for a fetch from the new target on the next cycle. No pipeline slot is spent on the branch itself. The target comes from an immediate supplied with the branch, from the held link register, or from the held count register.

A conditional branch carries a one-bit hint that picks the predicted direction. If the hint says taken, fetch is redirected at once. If it says not taken, fetch simply continues. From the cycle after acceptance until the condition resolves, the unit holds a writeback-inhibit output high. Work on the predicted path may execute but must not commit. The condition resolves in the first cycle in which the condition-register valid input is high, by comparing one selected condition bit against a required sense.

When the prediction is right, the inhibit drops and nothing else happens. When it is wrong, the unit raises a one-cycle flush and redirects fetch to the correct path: the target if the branch was actually taken, otherwise the branch address plus 4. A branch that asks to link writes the branch address plus 4 into the link register when it is actually taken. Software-side write ports load the link and count registers.

Top module: `branch_fold_unit`

## Requirements
- R1: After reset, `br_ready` is 1, and `redirect_valid`, `flush` and `wb_inhibit` are 0. The link and count registers read 0.
- R2: A branch accepted with `br_cond`=0 raises `redirect_valid` for exactly one cycle, on the cycle after acceptance, with `redirect_addr` equal to its target. It raises neither `flush` nor `wb_inhibit`.
- R3: The target source is set by `br_src`: 0 is `br_imm`, 1 is the link register value, 2 is the count register value, and 3 is `br_imm`. A register source uses the value held before the accepting edge.
- R4: The link register is written with `br_pc`+4 when a branch with `br_link`=1 is actually taken. That means at the accepting edge for an unconditional branch, and at the resolving edge for a conditional branch. `lr_we` and `ctr_we` load `wr_data` into the link and count registers. In the same cycle, a branch link write to the link register wins over `lr_we`.
- R5: A conditional branch with `br_hint`=1 redirects to its target on the cycle after acceptance. With `br_hint`=0 it causes no redirect at acceptance.
- R6: `wb_inhibit` is 1 from the cycle after a conditional branch is accepted up to and including the cycle in which it resolves. It is 0 from the cycle after resolution.
- R7: On a correct prediction, resolution causes neither a flush nor a redirect.
- R8: On a wrong prediction, `flush` and `redirect_valid` are both 1 for exactly the cycle after resolution. `redirect_addr` is the target if the branch was taken, otherwise `br_pc`+4.
- R9: `br_ready` is 0 while a conditional branch is unresolved. A `br_valid` presented then is ignored: it causes no redirect and no link write, and it is not picked up later.
- R10: A pending branch is taken when `cr_bits[br_sel]` equals `br_sense`. `cr_valid` while nothing is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_ready | output | 1 | A presented branch is accepted this cycle |
| br_cond | input | 1 | 1 = conditional branch, 0 = unconditional |
| br_src | input | 2 | Target source (0/3 immediate, 1 link, 2 count) |
| br_imm | input | AW | Immediate target address |
| br_pc | input | AW | Address of the branch instruction |
| br_hint | input | 1 | Predicted direction, 1 = taken |
| br_link | input | 1 | Load link register with return address when taken |
| br_sel | input | SW | Index of the condition bit tested |
| br_sense | input | 1 | Bit value that means taken |
| cr_valid | input | 1 | Condition bits are valid this cycle |
| cr_bits | input | CRW | Condition bits |
| lr_we | input | 1 | Load link register from wr_data |
| ctr_we | input | 1 | Load count register from wr_data |
| wr_data | input | AW | Data for link/count register loads |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_addr | output | AW | Fetch redirect address |
| flush | output | 1 | Discard everything after the mispredicted branch |
| wb_inhibit | output | 1 | Speculative writeback must be held back |
| lr_value | output | AW | Current link register |
| ctr_value | output | AW | Current count register |

## Verification
The hardest case to reach is a branch presented while another is unresolved. The ignored branch has to be shown to leave no trace. To get there, the bench holds a second branch with a distinct target and `br_link` set on the inputs for several cycles while a conditional is pending, then resolves it. A model that runs every cycle then confirms that no stray redirect or link write shows up. Mispredictions in both directions are forced by pairing each hint value with condition bits that contradict it. The link-write-versus-software-write collision is driven in a single cycle.

// File: rtl/bfu_pkg.sv
// Shared types for the branch folding unit.
// Assumes: target source encoding is fixed by the unit's requirements.
package bfu_pkg;
    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_LR  = 2'd1,
        SRC_CTR = 2'd2,
        SRC_ALT = 2'd3
    } tgt_src_e;
endpackage

// File: rtl/bfu_target_sel.sv
// Picks the branch target from immediate, link or count register and forms
// the fall-through address. Assumes fixed 4-byte instructions.
module bfu_target_sel
    import bfu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]    src,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] lr,
    input  logic [AW-1:0] ctr,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] tgt,
    output logic [AW-1:0] fall
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    // target multiplexer
    always_comb begin
        case (tgt_src_e'(src))
            SRC_LR:  tgt = lr;
            SRC_CTR: tgt = ctr;
            default: tgt = imm;
        endcase
    end

    // return / fall-through address
    assign fall = pc + INSN_BYTES;
endmodule

// File: rtl/bfu_linkctr.sv
// Holds the link and count registers. Branch link writes take priority
// over software loads of the link register in the same cycle.
module bfu_linkctr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_lr_we,
    input  logic          sw_ctr_we,
    input  logic [AW-1:0] sw_data,
    input  logic          br_lr_we,
    input  logic [AW-1:0] br_lr_data,
    output logic [AW-1:0] lr,
    output logic [AW-1:0] ctr
);
    // link register update
    always_ff @(posedge clk) begin
        if (!rst_n)        lr <= '0;
        else if (br_lr_we) lr <= br_lr_data;
        else if (sw_lr_we) lr <= sw_data;
    end

    // count register update
    always_ff @(posedge clk) begin
        if (!rst_n)         ctr <= '0;
        else if (sw_ctr_we) ctr <= sw_data;
    end
endmodule

// File: rtl/bfu_resolve.sv
// Tracks the single outstanding conditional branch, issues redirects and
// flushes, and requests link writes. Assumes accept is only high when no
// branch is pending.
module bfu_resolve #(
    parameter int AW  = 32,
    parameter int CRW = 8,
    localparam int SW = (CRW > 1) ? $clog2(CRW) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           is_cond,
    input  logic           hint,
    input  logic           link,
    input  logic [AW-1:0]  tgt,
    input  logic [AW-1:0]  fall,
    input  logic [SW-1:0]  sel,
    input  logic           sense,
    input  logic           cr_valid,
    input  logic [CRW-1:0] cr_bits,
    output logic           pending,
    output logic           redir_v,
    output logic [AW-1:0]  redir_a,
    output logic           flush_o,
    output logic           lr_we,
    output logic [AW-1:0]  lr_data
);
    logic          q_pred, q_link, q_sense;
    logic [SW-1:0] q_sel;
    logic [AW-1:0] q_tgt, q_fall;
    logic          resolving, outcome, mispredict, early_redir;

    // resolution decode
    always_comb begin
        resolving   = pending && cr_valid;
        outcome     = (cr_bits[q_sel] == q_sense);
        mispredict  = resolving && (outcome != q_pred);
        early_redir = accept && (!is_cond || hint);
        lr_we       = (accept && !is_cond && link) || (resolving && outcome && q_link);
        lr_data     = resolving ? q_fall : fall;
    end

    // pending branch state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            q_pred  <= 1'b0;
            q_link  <= 1'b0;
            q_sense <= 1'b0;
            q_sel   <= '0;
            q_tgt   <= '0;
            q_fall  <= '0;
        end else if (resolving) begin
            pending <= 1'b0;
        end else if (accept && is_cond) begin
            pending <= 1'b1;
            q_pred  <= hint;
            q_link  <= link;
            q_sense <= sense;
            q_sel   <= sel;
            q_tgt   <= tgt;
            q_fall  <= fall;
        end
    end

    // redirect and flush outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_v <= 1'b0;
            redir_a <= '0;
            flush_o <= 1'b0;
        end else begin
            redir_v <= early_redir || mispredict;
            flush_o <= mispredict;
            if (mispredict)       redir_a <= outcome ? q_tgt : q_fall;
            else if (early_redir) redir_a <= tgt;
        end
    end
endmodule

// File: rtl/branch_fold_unit.sv
// Top of the branch folding unit: one branch at a time, unconditional
// branches redirect at once, conditional ones follow a static hint and
// hold back writeback until the condition bits arrive.
module branch_fold_unit #(
    parameter int AW  = 32,
    parameter int CRW = 8,
    localparam int SW = (CRW > 1) ? $clog2(CRW) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           br_valid,
    output logic           br_ready,
    input  logic           br_cond,
    input  logic [1:0]     br_src,
    input  logic [AW-1:0]  br_imm,
    input  logic [AW-1:0]  br_pc,
    input  logic           br_hint,
    input  logic           br_link,
    input  logic [SW-1:0]  br_sel,
    input  logic           br_sense,
    input  logic           cr_valid,
    input  logic [CRW-1:0] cr_bits,
    input  logic           lr_we,
    input  logic           ctr_we,
    input  logic [AW-1:0]  wr_data,
    output logic           redirect_valid,
    output logic [AW-1:0]  redirect_addr,
    output logic           flush,
    output logic           wb_inhibit,
    output logic [AW-1:0]  lr_value,
    output logic [AW-1:0]  ctr_value
);
    logic          pending, accept, link_we;
    logic [AW-1:0] tgt, fall, link_data;

    // handshake: accept only with nothing outstanding
    assign br_ready   = !pending;
    assign accept     = br_valid && br_ready;
    assign wb_inhibit = pending;

    bfu_target_sel #(.AW(AW)) u_tsel (
        .src  (br_src),
        .imm  (br_imm),
        .lr   (lr_value),
        .ctr  (ctr_value),
        .pc   (br_pc),
        .tgt  (tgt),
        .fall (fall)
    );

    bfu_linkctr #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_lr_we   (lr_we),
        .sw_ctr_we  (ctr_we),
        .sw_data    (wr_data),
        .br_lr_we   (link_we),
        .br_lr_data (link_data),
        .lr         (lr_value),
        .ctr        (ctr_value)
    );

    bfu_resolve #(.AW(AW), .CRW(CRW)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .is_cond  (br_cond),
        .hint     (br_hint),
        .link     (br_link),
        .tgt      (tgt),
        .fall     (fall),
        .sel      (br_sel),
        .sense    (br_sense),
        .cr_valid (cr_valid),
        .cr_bits  (cr_bits),
        .pending  (pending),
        .redir_v  (redirect_valid),
        .redir_a  (redirect_addr),
        .flush_o  (flush),
        .lr_we    (link_we),
        .lr_data  (link_data)
    );
endmodule

// File: rtl/branch_fold_unit_chk.sv
// Protocol checks for the branch folding unit, bound to every instance.
module branch_fold_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic br_valid,
    input logic br_ready,
    input logic br_cond,
    input logic redirect_valid,
    input logic flush,
    input logic wb_inhibit
);
    // R2
    uncond_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_ready && !br_cond) |=> (redirect_valid && !flush));

    // R6
    cond_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_ready && br_cond) |=> wb_inhibit);

    // R8
    flush_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redirect_valid && !wb_inhibit && $past(wb_inhibit)));

    // R9
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_inhibit |-> !br_ready);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_inhibit && !(br_valid && br_ready)) |=> (!redirect_valid && !flush && !wb_inhibit));
endmodule

bind branch_fold_unit branch_fold_unit_chk u_chk (.*);

// File: tb/branch_fold_unit_tb.sv
`timescale 1ns/1ps
module branch_fold_unit_tb;
    localparam int AW = 32;
    localparam int CRW = 8;
    localparam int SW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic br_valid = 0, br_cond = 0, br_hint = 0, br_link = 0, br_sense = 0;
    logic [1:0] br_src = 0;
    logic [AW-1:0] br_imm = 0, br_pc = 0, wr_data = 0;
    logic [SW-1:0] br_sel = 0;
    logic cr_valid = 0, lr_we = 0, ctr_we = 0;
    logic [CRW-1:0] cr_bits = 0;
    logic br_ready, redirect_valid, flush, wb_inhibit;
    logic [AW-1:0] redirect_addr, lr_value, ctr_value;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    branch_fold_unit u_dut (.*);

    // behavioural reference state
    bit m_pend, m_pred, m_link, m_sense, m_redir, m_flush;
    int unsigned m_sel;
    logic [AW-1:0] m_tgt, m_fall, m_raddr, m_lr, m_ctr;

    always @(posedge clk) begin
        logic [AW-1:0] t, old_lr, old_ctr;
        bit outc;
        if (!rst_n) begin
            m_pend = 0; m_redir = 0; m_flush = 0; m_raddr = 0; m_lr = 0; m_ctr = 0;
        end else begin
            old_lr = m_lr; old_ctr = m_ctr;
            m_redir = 0; m_flush = 0;
            if (lr_we) m_lr = wr_data;
            if (ctr_we) m_ctr = wr_data;
            if (m_pend && cr_valid) begin
                outc = (cr_bits[m_sel] == m_sense);
                if (outc && m_link) m_lr = m_fall;
                if (outc != m_pred) begin
                    m_flush = 1; m_redir = 1;
                    m_raddr = outc ? m_tgt : m_fall;
                end
                m_pend = 0;
            end else if (!m_pend && br_valid) begin
                t = (br_src == 1) ? old_lr : (br_src == 2) ? old_ctr : br_imm;
                if (!br_cond) begin
                    m_redir = 1; m_raddr = t;
                    if (br_link) m_lr = br_pc + 4;
                end else begin
                    m_pend = 1; m_pred = br_hint; m_link = br_link;
                    m_sel = br_sel; m_sense = br_sense; m_tgt = t; m_fall = br_pc + 4;
                    if (br_hint) begin m_redir = 1; m_raddr = t; end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 br_ready", AW'(br_ready), AW'(!m_pend));
            chk("R2/R5 redirect_valid", AW'(redirect_valid), AW'(m_redir));
            if (m_redir) chk("R3 redirect_addr", redirect_addr, m_raddr);
            chk("R8 flush", AW'(flush), AW'(m_flush));
            chk("R6 wb_inhibit", AW'(wb_inhibit), AW'(m_pend));
            chk("R4 lr_value", lr_value, m_lr);
            chk("R4 ctr_value", ctr_value, m_ctr);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic issue(input bit c, input logic [1:0] s, input bit h, input bit l,
                         input logic [AW-1:0] pc, input logic [AW-1:0] imm,
                         input logic [SW-1:0] sl, input bit sn);
        br_valid = 1; br_cond = c; br_src = s; br_hint = h; br_link = l;
        br_pc = pc; br_imm = imm; br_sel = sl; br_sense = sn;
        @(negedge clk);
        br_valid = 0;
        #1;
    endtask

    task automatic resolve(input logic [CRW-1:0] bits);
        cr_valid = 1; cr_bits = bits;
        @(negedge clk);
        cr_valid = 0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 ready", AW'(br_ready), 1);
        chk("R1 redirect", AW'(redirect_valid), 0);
        chk("R1 flush", AW'(flush), 0);
        chk("R1 inhibit", AW'(wb_inhibit), 0);
        chk("R1 lr", lr_value, 0);
        @(negedge clk);
        // load link and count registers
        lr_we = 1; wr_data = 32'h100; @(negedge clk); lr_we = 0;
        ctr_we = 1; wr_data = 32'h200; @(negedge clk); ctr_we = 0;
        // R2 unconditional immediate
        issue(0, 0, 0, 0, 32'h40, 32'h80, 0, 0);
        chk("R2 redirect", AW'(redirect_valid), 1);
        chk("R2 addr", redirect_addr, 32'h80);
        idle(1);
        chk("R2 one pulse", AW'(redirect_valid), 0);
        // R3 link source with link write
        issue(0, 1, 0, 1, 32'h50, 32'h0, 0, 0);
        chk("R3 lr source", redirect_addr, 32'h100);
        chk("R4 link write", lr_value, 32'h54);
        issue(0, 2, 0, 0, 32'h58, 32'h0, 0, 0);
        chk("R3 ctr source", redirect_addr, 32'h200);
        issue(0, 3, 0, 0, 32'h5c, 32'h3c0, 0, 0);
        chk("R3 code 3 immediate", redirect_addr, 32'h3c0);
        // R5 hint taken, correct; stall with a second branch held
        issue(1, 0, 1, 0, 32'h60, 32'h90, 2, 1);
        chk("R5 early redirect", redirect_addr, 32'h90);
        chk("R6 inhibit high", AW'(wb_inhibit), 1);
        br_valid = 1; br_cond = 0; br_link = 1; br_src = 0; br_imm = 32'hdead0; br_pc = 32'h700;
        idle(3);
        chk("R9 stalled no redirect", AW'(redirect_valid), 0);
        chk("R9 stalled no link", lr_value, 32'h54);
        br_valid = 0; br_link = 0;
        resolve(8'h04);
        chk("R7 no flush", AW'(flush), 0);
        chk("R7 no redirect", AW'(redirect_valid), 0);
        chk("R6 inhibit low", AW'(wb_inhibit), 0);
        // R8 hint taken, actually not taken
        issue(1, 0, 1, 0, 32'h70, 32'ha0, 5, 1);
        idle(2);
        resolve(8'h00);
        chk("R8 flush", AW'(flush), 1);
        chk("R8 fall-through", redirect_addr, 32'h74);
        // R8 hint not taken, actually taken (sense 0)
        issue(1, 2, 0, 0, 32'h80, 32'h0, 7, 0);
        chk("R5 no early redirect", AW'(redirect_valid), 0);
        resolve(8'h7f);
        chk("R8 taken target", redirect_addr, 32'h200);
        chk("R10 sense 0 taken", AW'(flush), 1);
        // R7 hint not taken, correct
        issue(1, 0, 0, 1, 32'h90, 32'hb0, 1, 1);
        resolve(8'h00);
        chk("R7 correct not-taken", AW'(flush), 0);
        chk("R4 no link when not taken", lr_value, 32'h54);
        // R4 conditional with link, taken at resolution
        issue(1, 0, 0, 1, 32'ha0, 32'hc0, 3, 1);
        resolve(8'h08);
        chk("R4 cond link", lr_value, 32'ha4);
        // R10 idle condition valid, and condition valid in accept cycle
        resolve(8'hff);
        chk("R10 idle cr_valid", AW'(redirect_valid | flush), 0);
        cr_valid = 1; cr_bits = 8'h00;
        issue(1, 0, 1, 0, 32'hb0, 32'hd0, 0, 1);
        cr_valid = 0;
        chk("R10 still pending", AW'(wb_inhibit), 1);
        resolve(8'h01);
        // R4 software write collides with branch link
        lr_we = 1; wr_data = 32'h999;
        issue(0, 0, 0, 1, 32'hc0, 32'he0, 0, 0);
        lr_we = 0;
        chk("R4 branch link wins", lr_value, 32'hc4);
        idle(3);
        finish_run();
    end
endmodule